// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer Sequencer

This block turns single dialed digits into a train of line breaks for a subscriber loop. The line is opened and closed again at ten pulses per second. An upstream digit store offers one digit at a time with a strobe. It watches the busy flag and holds the next digit until the sequencer is back in idle. The same sequencer also runs a timed earth (flash) pulse followed by a recovery interval, and a plain dial pause. A short keytone enable gives acoustic feedback for each accepted digit, and a mute output silences the speech path while the pulses are on the line.

All timing is counted in ticks of a 1 ms timing strobe, and every interval length is a parameter. The block does nothing while the set is on-hook or while tone dialing is selected. Taking the handset back on-hook abandons whatever is running.

Top module: `pulse_dialer`

## Requirements
- R1: A digit code 1 to 9 produces that many line breaks, and code 0 produces 10. Codes 10 to 15 are not accepted: the strobe is ignored and the block stays idle.
- R2: With ratioSel = 0, each break lasts BRK_A ticks and each make lasts MAK_A ticks (66/34 ms by default). With ratioSel = 1 they last BRK_B and MAK_B ticks (60/40 ms by default). The pin is sampled in the clock cycle that accepts the digit.
- R3: mute is high from the first break to the end of the last make of a digit and low otherwise. lineBreak is never high without mute.
- R4: After the last make, a gap of GAP_T ticks (800 ms by default) follows with busy still high and lineBreak and mute low.
- R5: An earth request drives earthOut high for EARTH_T ticks (604 ms by default). A recovery interval of REST_T ticks (1000 ms by default) follows with busy high. No line breaks occur during either interval.
- R6: A pause request holds busy high for PAUSE_T ticks with lineBreak, mute and earthOut low.
- R7: keyTone goes high in the cycle a digit is accepted and stays high for TONE_T ticks. It does not go high for refused or invalid strobes.
- R8: When offHook is low, the block is idle at the next clock edge with all outputs low, and every request is ignored.
- R9: A digit strobe, earth request or pause request that arrives while busy is high is refused and has no later effect.
- R10: With pulseMode = 0 (tone dialing), every request is ignored.
- R11: When requests arrive together in idle, earth wins over a digit, and a digit wins over a pause. The losing requests are dropped.
- R12: After reset all outputs are low. Each interval starts in the accepting clock cycle and ends on its N-th later tick, so an interval of N ticks lasts exactly N tick periods when the request is accepted on a tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle 1 ms timing strobe |
| offHook | input | 1 | 1 = handset off-hook |
| pulseMode | input | 1 | 1 = pulse dialing, 0 = tone dialing |
| ratioSel | input | 1 | 0 = 66/34 break/make, 1 = 60/40 |
| digitStb | input | 1 | Offers digitCode for one cycle |
| digitCode | input | 4 | Digit value 0 to 9 |
| earthReq | input | 1 | Earth (flash) key request |
| pauseReq | input | 1 | Dial pause request |
| lineBreak | output | 1 | 1 = open the loop |
| mute | output | 1 | Speech path mute |
| earthOut | output | 1 | Earth pulse output |
| keyTone | output | 1 | Keytone enable |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with interval lengths cut down to a few ticks: 6/3 and 5/4 for the two break/make ratios, a gap of 8, an earth pulse of 7 with a rest of 10, a pause of 12 and a keytone of 4. A tick arrives every fourth clock. With these lengths, the ten-pulse digit, the whole earth and rest sequence, and aborts in the middle of a break can each be run to completion many times within a short run. Every interval can then be measured exactly in clocks, because each request is launched on a tick cycle.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_MAKE,
    ST_GAP,
    ST_EARTH,
    ST_REST,
    ST_PAUSE
  } phase_e;

  typedef enum logic [2:0] {
    LEN_BREAK,
    LEN_MAKE,
    LEN_GAP,
    LEN_EARTH,
    LEN_REST,
    LEN_PAUSE
  } len_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // load interval counter with lenSel
    len_e lenSel;
    logic takeDigit;  // latch pulse count, ratio, start keytone
    logic stepPulse;  // one break/make pair finished
    logic flush;      // abandon everything
  } step_t;

endpackage

// File: rtl/pd_datapath.sv
module pd_datapath
  import pd_pkg::*;
#(
  parameter int BRK_A   = 66,
  parameter int MAK_A   = 34,
  parameter int BRK_B   = 60,
  parameter int MAK_B   = 40,
  parameter int GAP_T   = 800,
  parameter int EARTH_T = 604,
  parameter int REST_T  = 1000,
  parameter int PAUSE_T = 2000,
  parameter int TONE_T  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  step_t      ctl,
  input  logic [3:0] digitCode,
  input  logic       ratioSel,
  output logic       phaseDone,
  output logic       lastPulse,
  output logic       keyTone
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXLEN = maxOf(maxOf(maxOf(BRK_A, MAK_A), maxOf(BRK_B, MAK_B)),
                                maxOf(maxOf(GAP_T, EARTH_T), maxOf(REST_T, PAUSE_T)));
  localparam int CW = $clog2(MAXLEN + 1);
  localparam int KW = $clog2(TONE_T + 1);
  localparam int PULSE_MAX = 10;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lenVal;
  logic [3:0]    pulsesLeft;
  logic [KW-1:0] toneCnt;
  logic          ratioQ;
  logic          ratioEff;

  // the ratio pin counts in the accepting cycle, then the latched copy
  assign ratioEff = ctl.takeDigit ? ratioSel : ratioQ;

  always_comb begin
    lenVal = '0;
    case (ctl.lenSel)
      LEN_BREAK: lenVal = ratioEff ? CW'(BRK_B) : CW'(BRK_A);
      LEN_MAKE:  lenVal = ratioEff ? CW'(MAK_B) : CW'(MAK_A);
      LEN_GAP:   lenVal = CW'(GAP_T);
      LEN_EARTH: lenVal = CW'(EARTH_T);
      LEN_REST:  lenVal = CW'(REST_T);
      LEN_PAUSE: lenVal = CW'(PAUSE_T);
      default:   lenVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.flush) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= lenVal;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign phaseDone = tick && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulsesLeft <= '0;
      ratioQ     <= 1'b0;
    end else if (ctl.flush) begin
      pulsesLeft <= '0;
    end else if (ctl.takeDigit) begin
      pulsesLeft <= (digitCode == 4'd0) ? 4'(PULSE_MAX) : digitCode;
      ratioQ     <= ratioSel;
    end else if (ctl.stepPulse && pulsesLeft != '0) begin
      pulsesLeft <= pulsesLeft - 1'b1;
    end
  end

  assign lastPulse = (pulsesLeft == 4'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toneCnt <= '0;
    end else if (ctl.flush) begin
      toneCnt <= '0;
    end else if (ctl.takeDigit) begin
      toneCnt <= KW'(TONE_T);
    end else if (tick && toneCnt != '0) begin
      toneCnt <= toneCnt - 1'b1;
    end
  end

  assign keyTone = (toneCnt != '0);

  // R1: the pulse store never exceeds the ten pulses of digit zero
  p_pulses_bounded_r1: assert property (@(posedge clk) disable iff (!rstN)
    pulsesLeft <= 4'(PULSE_MAX));

  // R12: without a tick or a load the interval counter holds
  p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctl.load && !ctl.flush) |=> $stable(cnt));

endmodule

// File: rtl/pd_control.sv
module pd_control
  import pd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       offHook,
  input  logic       pulseMode,
  input  logic       digitStb,
  input  logic [3:0] digitCode,
  input  logic       earthReq,
  input  logic       pauseReq,
  input  logic       phaseDone,
  input  logic       lastPulse,
  output step_t      ctl,
  output logic       lineBreak,
  output logic       mute,
  output logic       earthOut,
  output logic       busy
);

  phase_e phase, nxt;
  logic   codeOk;

  assign codeOk = (digitCode <= 4'd9);

  always_comb begin
    nxt = phase;
    ctl = '0;
    if (!offHook) begin
      nxt       = ST_IDLE;
      ctl.flush = 1'b1;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (pulseMode) begin
            if (earthReq) begin
              nxt        = ST_EARTH;
              ctl.load   = 1'b1;
              ctl.lenSel = LEN_EARTH;
            end else if (digitStb && codeOk) begin
              nxt           = ST_BREAK;
              ctl.load      = 1'b1;
              ctl.lenSel    = LEN_BREAK;
              ctl.takeDigit = 1'b1;
            end else if (pauseReq) begin
              nxt        = ST_PAUSE;
              ctl.load   = 1'b1;
              ctl.lenSel = LEN_PAUSE;
            end
          end
        end
        ST_BREAK: begin
          if (phaseDone) begin
            nxt        = ST_MAKE;
            ctl.load   = 1'b1;
            ctl.lenSel = LEN_MAKE;
          end
        end
        ST_MAKE: begin
          if (phaseDone) begin
            ctl.load = 1'b1;
            if (lastPulse) begin
              nxt        = ST_GAP;
              ctl.lenSel = LEN_GAP;
            end else begin
              nxt           = ST_BREAK;
              ctl.lenSel    = LEN_BREAK;
              ctl.stepPulse = 1'b1;
            end
          end
        end
        ST_EARTH: begin
          if (phaseDone) begin
            nxt        = ST_REST;
            ctl.load   = 1'b1;
            ctl.lenSel = LEN_REST;
          end
        end
        ST_GAP, ST_REST, ST_PAUSE: begin
          if (phaseDone) nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= nxt;
  end

  assign lineBreak = (phase == ST_BREAK);
  assign mute      = (phase == ST_BREAK) || (phase == ST_MAKE);
  assign earthOut  = (phase == ST_EARTH);
  assign busy      = (phase != ST_IDLE);

  // R3: mute only ends by entering the inter-digit gap while off-hook
  p_mute_ends_in_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mute) && offHook) |-> (phase == ST_GAP));

  // R5: the earth pulse is always followed by its recovery interval
  p_earth_then_rest_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(earthOut) && offHook) |-> (phase == ST_REST));

  // R11: a new sequence only ever starts from idle
  p_start_from_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(phase) == ST_IDLE));

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
  import pd_pkg::*;
#(
  parameter int BRK_A   = 66,
  parameter int MAK_A   = 34,
  parameter int BRK_B   = 60,
  parameter int MAK_B   = 40,
  parameter int GAP_T   = 800,
  parameter int EARTH_T = 604,
  parameter int REST_T  = 1000,
  parameter int PAUSE_T = 2000,
  parameter int TONE_T  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       offHook,
  input  logic       pulseMode,
  input  logic       ratioSel,
  input  logic       digitStb,
  input  logic [3:0] digitCode,
  input  logic       earthReq,
  input  logic       pauseReq,
  output logic       lineBreak,
  output logic       mute,
  output logic       earthOut,
  output logic       keyTone,
  output logic       busy
);

  step_t ctl;
  logic  phaseDone;
  logic  lastPulse;

  pd_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .offHook   (offHook),
    .pulseMode (pulseMode),
    .digitStb  (digitStb),
    .digitCode (digitCode),
    .earthReq  (earthReq),
    .pauseReq  (pauseReq),
    .phaseDone (phaseDone),
    .lastPulse (lastPulse),
    .ctl       (ctl),
    .lineBreak (lineBreak),
    .mute      (mute),
    .earthOut  (earthOut),
    .busy      (busy)
  );

  pd_datapath #(
    .BRK_A(BRK_A), .MAK_A(MAK_A), .BRK_B(BRK_B), .MAK_B(MAK_B),
    .GAP_T(GAP_T), .EARTH_T(EARTH_T), .REST_T(REST_T),
    .PAUSE_T(PAUSE_T), .TONE_T(TONE_T)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .ctl       (ctl),
    .digitCode (digitCode),
    .ratioSel  (ratioSel),
    .phaseDone (phaseDone),
    .lastPulse (lastPulse),
    .keyTone   (keyTone)
  );

  // R8: on-hook returns everything to rest at the next edge
  p_onhook_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !offHook |=> (!busy && !keyTone));

  // R9: a keytone can only start from an idle sequencer
  p_tone_only_from_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyTone) |-> $past(!busy));

endmodule

// File: tb/pulse_dialer_tb.sv
module pulse_dialer_tb;
  localparam int BA = 6, MA = 3, BB = 5, MB = 4;
  localparam int GP = 8, ET = 7, RT = 10, PT = 12, KT = 4, DIV = 4;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic offHook = 1'b1, pulseMode = 1'b1, ratioSel = 1'b0;
  logic digitStb = 1'b0, earthReq = 1'b0, pauseReq = 1'b0;
  logic [3:0] digitCode = 4'd0;
  logic lineBreak, mute, earthOut, keyTone, busy;

  always #10 clk = ~clk;

  pulse_dialer #(
    .BRK_A(BA), .MAK_A(MA), .BRK_B(BB), .MAK_B(MB), .GAP_T(GP),
    .EARTH_T(ET), .REST_T(RT), .PAUSE_T(PT), .TONE_T(KT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .offHook(offHook),
    .pulseMode(pulseMode), .ratioSel(ratioSel), .digitStb(digitStb),
    .digitCode(digitCode), .earthReq(earthReq), .pauseReq(pauseReq),
    .lineBreak(lineBreak), .mute(mute), .earthOut(earthOut),
    .keyTone(keyTone), .busy(busy)
  );

  int divCnt = 0;
  always @(negedge clk) begin
    divCnt <= (divCnt == DIV - 1) ? 0 : divCnt + 1;
    tick   <= (divCnt == DIV - 1);
  end

  // cumulative monitors, sampled at the falling edge
  int cBusy = 0, cBreak = 0, cMute = 0, cEarth = 0, cTone = 0, cPulse = 0, cOdd = 0;
  logic prevBrk = 1'b0;
  always @(negedge clk) begin
    cBusy  <= cBusy + int'(busy);
    cBreak <= cBreak + int'(lineBreak);
    cMute  <= cMute + int'(mute);
    cEarth <= cEarth + int'(earthOut);
    cTone  <= cTone + int'(keyTone);
    cPulse <= cPulse + int'(lineBreak && !prevBrk);
    cOdd   <= cOdd + int'(lineBreak && (!mute || earthOut));
    prevBrk <= lineBreak;
  end

  int total = 0, bad = 0;
  int sBusy, sBreak, sMute, sEarth, sTone, sPulse, sOdd;
  int dBusy, dBreak, dMute, dEarth, dTone, dPulse, dOdd;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pulsesFor(input logic [3:0] code);
    if (code == 4'd0) return 10;
    if (code <= 4'd9) return int'(code);
    return 0;
  endfunction

  // launch requests in a clock whose rising edge carries a tick
  task automatic go(input logic [3:0] code, input logic dS, input logic eR,
                    input logic pR, input logic rat);
    @(negedge clk); #1;
    while (tick !== 1'b1) begin @(negedge clk); #1; end
    sBusy = cBusy; sBreak = cBreak; sMute = cMute; sEarth = cEarth;
    sTone = cTone; sPulse = cPulse; sOdd = cOdd;
    digitCode = code; digitStb = dS; earthReq = eR; pauseReq = pR; ratioSel = rat;
    @(negedge clk); #1;
    digitStb = 1'b0; earthReq = 1'b0; pauseReq = 1'b0;
  endtask

  task automatic finishRun();
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); #1; guard++; end
    repeat (2) @(negedge clk);
    #1;
    dBusy = cBusy - sBusy; dBreak = cBreak - sBreak; dMute = cMute - sMute;
    dEarth = cEarth - sEarth; dTone = cTone - sTone; dPulse = cPulse - sPulse;
    dOdd = cOdd - sOdd;
  endtask

  // {ratioSel, digitCode}
  localparam logic [4:0] VEC [0:7] = '{5'h01, 5'h05, 5'h10, 5'h19,
                                       5'h00, 5'h13, 5'h0C, 5'h1F};

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R12: reset state
    chk("R12 reset busy", int'(busy), 0);
    chk("R12 reset lineBreak", int'(lineBreak), 0);
    chk("R12 reset outputs", int'(mute | earthOut | keyTone), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R1 R2 R3 R4 R7 R12
    for (int i = 0; i < 8; i++) begin
      logic rat;
      logic [3:0] code;
      int np, br, mk;
      rat = VEC[i][4];
      code = VEC[i][3:0];
      np = pulsesFor(code);
      br = rat ? BB : BA;
      mk = rat ? MB : MA;
      go(code, 1'b1, 1'b0, 1'b0, rat);
      finishRun();
      chk("R1 pulse count", dPulse, np);
      chk("R2 break time", dBreak, np * br * DIV);
      chk("R3 mute time", dMute, np * (br + mk) * DIV);
      chk("R4 busy time", dBusy, (np == 0) ? 0 : (np * (br + mk) + GP) * DIV);
      chk("R7 keytone time", dTone, (np == 0) ? 0 : KT * DIV);
      chk("R3 break outside mute", dOdd, 0);
    end

    // R9: second strobe and earth while busy are refused
    go(4'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    #1;
    digitCode = 4'd5; digitStb = 1'b1; earthReq = 1'b1;
    @(negedge clk); #1;
    digitStb = 1'b0; earthReq = 1'b0;
    finishRun();
    chk("R9 pulses after refused strobe", dPulse, 2);
    chk("R9 busy after refused strobe", dBusy, (2 * (BA + MA) + GP) * DIV);
    chk("R9 no earth while busy", dEarth, 0);
    chk("R9 keytone once", dTone, KT * DIV);

    // R5: earth pulse and recovery
    go(4'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    finishRun();
    chk("R5 earth time", dEarth, ET * DIV);
    chk("R5 busy time", dBusy, (ET + RT) * DIV);
    chk("R5 no breaks", dBreak, 0);

    // R6: pause
    go(4'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    finishRun();
    chk("R6 pause busy", dBusy, PT * DIV);
    chk("R6 quiet outputs", dBreak + dMute + dEarth + dTone, 0);

    // R11: earth beats digit and pause
    go(4'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    finishRun();
    chk("R11 earth wins", dEarth, ET * DIV);
    chk("R11 digit dropped", dPulse + dTone, 0);
    chk("R11 busy earth only", dBusy, (ET + RT) * DIV);

    // R11: digit beats pause
    go(4'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    finishRun();
    chk("R11 digit wins", dPulse, 3);
    chk("R11 pause dropped", dBusy, (3 * (BB + MB) + GP) * DIV);

    // R10: tone dialing mode ignores everything
    pulseMode = 1'b0;
    go(4'd4, 1'b1, 1'b1, 1'b1, 1'b0);
    finishRun();
    chk("R10 ignored in tone mode", dBusy + dTone + dEarth, 0);
    pulseMode = 1'b1;

    // R8: on-hook aborts mid-train
    go(4'd9, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    #1;
    chk("R8 running before abort", int'(busy), 1);
    offHook = 1'b0;
    @(negedge clk); #1;
    chk("R8 busy after abort", int'(busy), 0);
    chk("R8 outputs after abort", int'(lineBreak | mute | keyTone | earthOut), 0);
    go(4'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    #1;
    chk("R8 requests ignored on-hook", cBusy - sBusy + cTone - sTone, 0);
    offHook = 1'b1;
    repeat (3) @(negedge clk);

    // R8: fresh digit after abort runs in full
    go(4'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    finishRun();
    chk("R8 clean restart", dPulse, 1);
    chk("R12 restart busy", dBusy, ((BA + MA) + GP) * DIV);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule